// File: doc/BRIEF.md
# Prioritized PCI Interrupt Aggregator

This block merges four level-sensitive interrupt request lines into one processor interrupt. Three of the lines come from PCI devices and one comes from the PCI host-controller core. Each cycle the block samples the lines into a status register. It combines the status register with a software-owned enable register and raises a single request line whenever any enabled source is pending.

Alongside the combined request, the block reports which source an interrupt handler should service first. Devices take precedence over the core, and lower-numbered devices take precedence over higher-numbered ones. When nothing enabled is pending, the index output carries a dedicated "spurious" code, so a handler that is woken without cause can tell that it was.

Software reaches both registers through a one-bit-address register port. Reads are combinational from the stored state. Writes land on the next clock edge, which lets a mask or unmask done as read-modify-write read back its new value straight away.

Top module: `irq_agg`

## Requirements
- R1: While reset is asserted and after it is released, the status register and the enable register both read as 0x00, `irqOut` is 0 and `irqIdx` is 7.
- R2: Select value 0 reads the status register. Its bit 0, bit 1 and bit 2 equal `devIrq[0]`, `devIrq[1]` and `devIrq[2]` as sampled at the previous rising clock edge, and its bit 4 equals `coreIrq` as sampled at that edge.
- R3: A write with select value 1 stores the write data into the enable register at the rising edge. A read with select value 1 in the next cycle returns the data ANDed with 0x17.
- R4: Bit 3 and bits 7..5 of both registers always read as 0. Setting those bits in the write data changes neither a read-back nor the outputs.
- R5: `irqOut` is 1 exactly when status AND enable is non-zero.
- R6: `irqIdx` names the lowest-numbered bit of status AND enable. It gives 0, 1, 2 or 4, so device 0 beats device 1, device 1 beats device 2, and device 2 beats the core.
- R7: `irqIdx` is 7 whenever status AND enable is zero, including when sources are active but masked.
- R8: A write with select value 0 changes neither register. The status register keeps following the lines and the enable register keeps its value.
- R9: A read-modify-write that flips a single enable bit leaves the other enable bits unchanged. The new value is visible on the following read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| devIrq | input | NUM_DEV | Level request lines from the PCI devices |
| coreIrq | input | 1 | Level request line from the host-controller core |
| busSel | input | 1 | Register select: 0 status, 1 enable |
| busWrEn | input | 1 | Write strobe for the selected register |
| busWrData | input | REG_W | Write data |
| busRdData | output | REG_W | Read data of the selected register |
| irqOut | output | 1 | Combined interrupt request to the processor |
| irqIdx | output | IDX_W | Highest-priority pending source, 7 when none |

## Verification
A change on a source line shows up in the status read-back, in `irqOut` and in `irqIdx` exactly one rising edge later. An enable write becomes visible at the same point, one edge after its strobe. There is no further latency, because the read mux, the OR and the priority encoder are all combinational on the registers. The bench therefore changes inputs on a falling edge and samples on the next falling edge, which is half a period after the one register stage has loaded. It sweeps every one of the 256 write-data values against all 16 line patterns and computes the expected index and read-back arithmetically.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  // Strobes from the bus decoder to the register datapath.
  typedef struct packed {
    logic enableWr;    // load the enable register this edge
    logic readEnable;  // read mux selects the enable register
  } ctrlStrobe_t;

  // Bit map of implemented sources: devices at the low bits, core at corePos.
  function automatic logic [31:0] sourceMask(input int numDev, input int corePos);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < numDev; i++) m[i] = 1'b1;
    m[corePos] = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
(
  input  logic        busSel,
  input  logic        busWrEn,
  output ctrlStrobe_t strobe
);

  // Writes aimed at the status address produce no strobe at all.
  always_comb begin
    strobe.enableWr   = busWrEn & busSel;
    strobe.readEnable = busSel;
  end

endmodule

// File: rtl/irq_agg_prio.sv
module irq_agg_prio #(
  parameter int REG_W = 8,
  parameter int IDX_W = 3
) (
  input  logic [REG_W-1:0] pending,
  output logic [IDX_W-1:0] winIdx
);

  // Scan from the top down so that the lowest set bit is written last and wins.
  always_comb begin
    winIdx = '1;
    for (int i = REG_W - 1; i >= 0; i--) begin
      if (pending[i]) winIdx = IDX_W'(i);
    end
  end

endmodule

// File: rtl/irq_agg_dp.sv
module irq_agg_dp
  import irq_agg_pkg::*;
#(
  parameter int NUM_DEV  = 3,
  parameter int CORE_POS = 4,
  parameter int REG_W    = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_DEV-1:0] devIrq,
  input  logic               coreIrq,
  input  ctrlStrobe_t        strobe,
  input  logic [REG_W-1:0]   busWrData,
  output logic [REG_W-1:0]   busRdData,
  output logic [REG_W-1:0]   pending,
  output logic               anyPending
);

  localparam logic [REG_W-1:0] VALID_MASK = REG_W'(sourceMask(NUM_DEV, CORE_POS));

  logic [REG_W-1:0] srcVec;
  logic [REG_W-1:0] statusReg;
  logic [REG_W-1:0] enableReg;

  // Place each source line at its fixed bit; unused bits are tied low.
  for (genvar b = 0; b < REG_W; b++) begin : g_map
    if (b < NUM_DEV) begin : g_dev
      assign srcVec[b] = devIrq[b];
    end else if (b == CORE_POS) begin : g_core
      assign srcVec[b] = coreIrq;
    end else begin : g_none
      assign srcVec[b] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusReg <= '0;
      enableReg <= '0;
    end else begin
      statusReg <= srcVec;
      if (strobe.enableWr) enableReg <= busWrData & VALID_MASK;
    end
  end

  always_comb begin
    pending    = statusReg & enableReg;
    anyPending = |pending;
    busRdData  = strobe.readEnable ? enableReg : statusReg;
  end

endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
#(
  parameter int NUM_DEV  = 3,
  parameter int CORE_POS = 4,
  parameter int REG_W    = 8,
  localparam int IDX_W   = $clog2(REG_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_DEV-1:0] devIrq,
  input  logic               coreIrq,
  input  logic               busSel,
  input  logic               busWrEn,
  input  logic [REG_W-1:0]   busWrData,
  output logic [REG_W-1:0]   busRdData,
  output logic               irqOut,
  output logic [IDX_W-1:0]   irqIdx
);

  ctrlStrobe_t      strobe;
  logic [REG_W-1:0] pending;

  irq_agg_ctrl u_ctrl (
    .busSel (busSel),
    .busWrEn(busWrEn),
    .strobe (strobe)
  );

  irq_agg_dp #(
    .NUM_DEV (NUM_DEV),
    .CORE_POS(CORE_POS),
    .REG_W   (REG_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .devIrq    (devIrq),
    .coreIrq   (coreIrq),
    .strobe    (strobe),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .pending   (pending),
    .anyPending(irqOut)
  );

  irq_agg_prio #(
    .REG_W(REG_W),
    .IDX_W(IDX_W)
  ) u_prio (
    .pending(pending),
    .winIdx (irqIdx)
  );

endmodule

// File: rtl/irq_agg_checker.sv
module irq_agg_checker
  import irq_agg_pkg::*;
#(
  parameter int NUM_DEV  = 3,
  parameter int CORE_POS = 4,
  parameter int REG_W    = 8,
  parameter int IDX_W    = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_DEV-1:0] devIrq,
  input logic               coreIrq,
  input logic               busSel,
  input logic               busWrEn,
  input logic [REG_W-1:0]   busWrData,
  input logic [REG_W-1:0]   busRdData,
  input logic               irqOut,
  input logic [IDX_W-1:0]   irqIdx
);

  localparam logic [REG_W-1:0] VALID_MASK = REG_W'(sourceMask(NUM_DEV, CORE_POS));
  localparam logic [IDX_W-1:0] SPUR_IDX   = '1;

  logic             pastValid;
  logic [REG_W-1:0] expLines;

  always_ff @(posedge clk) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  always_comb begin
    expLines = '0;
    for (int i = 0; i < NUM_DEV; i++) expLines[i] = devIrq[i];
    expLines[CORE_POS] = coreIrq;
  end

  // R2: status read-back equals the lines sampled one edge earlier
  assert_status_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    pastValid |=> (busSel || busRdData == $past(expLines)));

  // R3: enable write is visible, masked, in the next cycle
  assert_enable_readback_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busSel) |=> (!busSel || busRdData == ($past(busWrData) & VALID_MASK)));

  // R4: unimplemented bits never read as one
  assert_unused_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busRdData & ~VALID_MASK) == '0);

  // R5 / R7: the combined line and the spurious code agree
  assert_out_vs_idx_R5: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (irqIdx != SPUR_IDX));

  // R6: the winning index always names an implemented source
  assert_idx_legal_R6: assert property (@(posedge clk) disable iff (!rstN)
    (irqIdx != SPUR_IDX) |-> VALID_MASK[irqIdx]);

endmodule

bind irq_agg irq_agg_checker #(
  .NUM_DEV (NUM_DEV),
  .CORE_POS(CORE_POS),
  .REG_W   (REG_W),
  .IDX_W   (IDX_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .devIrq   (devIrq),
  .coreIrq  (coreIrq),
  .busSel   (busSel),
  .busWrEn  (busWrEn),
  .busWrData(busWrData),
  .busRdData(busRdData),
  .irqOut   (irqOut),
  .irqIdx   (irqIdx)
);

// File: tb/irq_agg_test.sv
module irq_agg_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] devIrq = '0;
  logic       coreIrq = 1'b0;
  logic       busSel = 1'b0;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic       irqOut;
  logic [2:0] irqIdx;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  irq_agg uut (
    .clk(clk), .rstN(rstN), .devIrq(devIrq), .coreIrq(coreIrq),
    .busSel(busSel), .busWrEn(busWrEn), .busWrData(busWrData),
    .busRdData(busRdData), .irqOut(irqOut), .irqIdx(irqIdx)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic readReg(input logic sel, output logic [7:0] val);
    busSel = sel;
    #1;
    val = busRdData;
  endtask

  task automatic busWrite(input logic sel, input logic [7:0] data);
    @(negedge clk);
    busSel = sel; busWrEn = 1'b1; busWrData = data;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  function automatic logic [2:0] expIdx(input logic [7:0] p);
    if (p[0])      return 3'd0;
    else if (p[1]) return 3'd1;
    else if (p[2]) return 3'd2;
    else if (p[4]) return 3'd4;
    else           return 3'd7;
  endfunction

  task automatic checkOutputs(input string tag, input logic [7:0] st, input logic [7:0] en);
    logic [7:0] p;
    p = st & en;
    check({tag, " irqOut R5"}, {7'd0, irqOut}, {7'd0, p != 8'd0});
    check({tag, " irqIdx R6 R7"}, {5'd0, irqIdx}, {5'd0, expIdx(p)});
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] rd, st, en;

    // R1: state held in reset and right after release
    repeat (3) @(negedge clk);
    readReg(1'b0, rd); check("R1 status in reset", rd, 8'h00);
    readReg(1'b1, rd); check("R1 enable in reset", rd, 8'h00);
    check("R1 idx in reset", {5'd0, irqIdx}, 8'd7);
    rstN = 1'b1;
    @(negedge clk);
    readReg(1'b0, rd); check("R1 status after reset", rd, 8'h00);
    readReg(1'b1, rd); check("R1 enable after reset", rd, 8'h00);
    checkOutputs("R1", 8'h00, 8'h00);

    // Sweep all write data against all line patterns (R2..R7)
    for (int e = 0; e < 256; e++) begin
      busWrite(1'b1, 8'(e));
      en = 8'(e) & 8'h17;
      readReg(1'b1, rd); check("R3 R4 enable readback", rd, en);
      for (int l = 0; l < 16; l++) begin
        devIrq = l[2:0]; coreIrq = l[3];
        @(negedge clk);
        st = {3'b000, l[3], 1'b0, l[2:0]};
        readReg(1'b0, rd); check("R2 R4 status readback", rd, st);
        checkOutputs("R5 R6 R7 sweep", st, en);
      end
    end

    // R7: active but fully masked sources give the spurious code
    busWrite(1'b1, 8'h00);
    devIrq = 3'b111; coreIrq = 1'b1;
    @(negedge clk);
    check("R7 masked idx", {5'd0, irqIdx}, 8'd7);
    check("R7 masked irqOut", {7'd0, irqOut}, 8'd0);

    // R8: write to status address has no effect on either register
    busWrite(1'b1, 8'h12);
    devIrq = 3'b000; coreIrq = 1'b0;
    busWrite(1'b0, 8'hFF);
    readReg(1'b0, rd); check("R8 status after write", rd, 8'h00);
    readReg(1'b1, rd); check("R8 enable after write", rd, 8'h12);
    checkOutputs("R8", 8'h00, 8'h12);

    // R9: read-modify-write of single enable bits
    devIrq = 3'b011; coreIrq = 1'b1;
    busWrite(1'b1, 8'h17);
    readReg(1'b1, rd);
    busWrite(1'b1, rd & ~8'h01);
    readReg(1'b1, rd); check("R9 clear bit0", rd, 8'h16);
    check("R9 idx after clear", {5'd0, irqIdx}, 8'd1);
    busWrite(1'b1, rd & ~8'h02);
    readReg(1'b1, rd); check("R9 clear bit1", rd, 8'h14);
    check("R9 idx to core", {5'd0, irqIdx}, 8'd4);
    busWrite(1'b1, rd | 8'h01);
    readReg(1'b1, rd); check("R9 set bit0", rd, 8'h15);
    check("R9 idx back to dev0", {5'd0, irqIdx}, 8'd0);

    // R1: reset again mid-run clears both registers
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    readReg(1'b1, rd); check("R1 enable re-reset", rd, 8'h00);
    readReg(1'b0, rd); check("R1 status re-reset", rd, 8'h00);
    check("R1 idx re-reset", {5'd0, irqIdx}, 8'd7);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule